// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Sequencer

This block sits on the host side of an asynchronous parallel NOR-style flash and turns single requests into correctly timed bus cycles. A request carries a direction, an address and, for writes, a data word. The block drives the flash reset pin, three chip-enable lines (each with its own active level), the write and output strobes, the address bus and the data bus with its drive enable. It returns read data with a one-cycle valid pulse.

Every timing minimum is a parameter expressed in whole system-clock cycles. Separate counters gate each strobe edge. On a write, chip-enable leads the write strobe, so the effective pulse runs from the chip-enable edge to the write-strobe rise. That lead lets the write strobe itself be shorter by a fixed credit. A counter of cycles since the last write-strobe rise holds off the output strobe for reads. The same counter tells the host when the flash busy/status pin may be trusted.

Top module: `pflash_wr_seq`

## Requirements
- R1: While the reset input is low and until `T_RST_LO + 2` cycles after it is released, `fl_rst_n` is low, `req_ready` is low and both strobes are high. The 2 cycles come from the reset synchroniser.
- R2: `req_ready` first rises exactly `T_RST_REC` cycles after `fl_rst_n` rises. No write-strobe fall occurs earlier than that.
- R3: A write asserts the chip enables, presents the request address on `fl_addr`, presents the data on `fl_dq_out` and sets `fl_dq_oe`, all on the same edge. `fl_we_n` falls exactly `T_CE_LEAD` cycles later.
- R4: `fl_we_n` stays low for exactly WE_LOW cycles, where WE_LOW = max(T_WP − credit, T_WP − T_CE_LEAD, T_DS − T_CE_LEAD). The credit is `T_WP_CREDIT` when `T_CE_LEAD ≥ T_WP_CREDIT` and 0 otherwise. The interval from chip-enable to the write-strobe rise is at least `T_WP`. Address and data are stable for at least `T_DS` cycles before the rise.
- R5: The chip enables are released on the same edge as the write-strobe rise. Address, data and `fl_dq_oe` do not change for at least `T_DH` cycles after that rise.
- R6: From any strobe-ending edge (write-strobe rise or chip-enable release) to the next chip-enable assertion, at least `T_WPH` cycles pass. After a write is accepted, `req_ready` returns after exactly T_CE_LEAD + WE_LOW + max(T_WPH, T_DH) + 1 cycles.
- R7: `fl_oe_n` never falls earlier than `T_WHGL` cycles after the latest write-strobe rise.
- R8: A read holds `fl_oe_n` low with the chip enables asserted for exactly `T_RD_ACC` cycles, with `fl_dq_oe` low. It captures `fl_dq_in` on the last of those cycles into `rd_data` and raises `rd_valid` for one cycle.
- R9: `sts_settled` is low from each write-strobe rise until exactly `T_STS` cycles after it, and high from then on.
- R10: The chip enables switch together. Line i is at `CE_ON_LVL[i]` when enabled and at its inverse otherwise.
- R11: `req_valid` has no effect while `req_ready` is low. No new cycle starts and `fl_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| sts_settled | output | 1 | Busy/status pin may be sampled |
| fl_rst_n | output | 1 | Flash reset pin |
| fl_ce | output | 3 | Chip-enable lines, per-line active level |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output strobe, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_in | input | DW | Data returned by the flash |

## Verification
The hardest interval to provoke is the read hold-off after a write. The ready handshake already keeps the block busy through the pulse-high interval, so a read can only land close to a write-strobe rise when it is requested at the very first ready cycle. The bench therefore issues a read immediately after a write completes, with no idle gap, and the bus monitor measures the distance between the two strobes. Back-to-back writes and a request held while ready is low press on the pulse-high spacing and on the ignore rule in the same way.

// File: rtl/pfws_pkg.sv
package pfws_pkg;

  typedef enum logic [3:0] {
    S_RST_LO,
    S_RST_REC,
    S_IDLE,
    S_W_LEAD,
    S_W_PULSE,
    S_W_HIGH,
    S_R_WAIT,
    S_R_OE,
    S_R_REC
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfws_rst_sync.sv
module pfws_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pfws_interval.sv
module pfws_interval #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pfws_since.sv
module pfws_since #(
  parameter int W   = 5,
  parameter int SAT = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != W'(SAT));
    cnt_d  = restart ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= W'(SAT);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pfws_ce_drive.sv
module pfws_ce_drive #(
  parameter int         N      = 3,
  parameter logic [N-1:0] ON_LVL = '0
) (
  input  logic         en,
  output logic [N-1:0] ce
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (ON_LVL[i]) begin : g_hi
      assign ce[i] = en;
    end else begin : g_lo
      assign ce[i] = ~en;
    end
  end
endmodule

// File: rtl/pflash_wr_seq.sv
module pflash_wr_seq
  import pfws_pkg::*;
#(
  parameter int         AW          = 23,
  parameter int         DW          = 16,
  parameter logic [2:0] CE_ON_LVL   = 3'b010,
  parameter int         T_RST_LO    = 4,
  parameter int         T_RST_REC   = 201,
  parameter int         T_CE_LEAD   = 3,
  parameter int         T_WP        = 14,
  parameter int         T_WP_CREDIT = 2,
  parameter int         T_DS        = 11,
  parameter int         T_DH        = 2,
  parameter int         T_WPH       = 6,
  parameter int         T_WHGL      = 7,
  parameter int         T_STS       = 18,
  parameter int         T_RD_ACC    = 8,
  parameter int         T_RD_REC    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          sts_settled,
  output logic          fl_rst_n,
  output logic [2:0]    fl_ce,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);
  // Derived cycle counts
  localparam int WE_CREDIT = (T_CE_LEAD >= T_WP_CREDIT) ? T_WP_CREDIT : 0;
  localparam int WE_LOW    = imax(1, imax(imax(T_WP - WE_CREDIT, T_WP - T_CE_LEAD),
                                          T_DS - T_CE_LEAD));
  localparam int WR_HIGH   = imax(T_WPH, T_DH);
  localparam int TMAX      = imax(imax(imax(T_RST_LO, T_RST_REC), imax(WE_LOW, WR_HIGH)),
                                  imax(imax(T_CE_LEAD, T_RD_ACC), T_RD_REC));
  localparam int TW        = $clog2(TMAX + 1);
  localparam int SMAX      = imax(T_WHGL, T_STS);
  localparam int SW        = $clog2(SMAX + 1);

  logic              rst_n_int;
  seq_state_t        st_q, st_d;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  logic              accept, we_rise, rd_ok;
  logic [SW-1:0]     since_we;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q, rdat_q;
  logic              rval_q, rst_pin_q, ce_en_q, we_n_q, oe_n_q, dq_oe_q;

  pfws_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  pfws_interval #(.W(TW), .RST_VAL(T_RST_LO - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n_int), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  pfws_since #(.W(SW), .SAT(SMAX)) u_since (
    .clk(clk), .rst_n(rst_n_int), .restart(we_rise), .cnt(since_we)
  );

  pfws_ce_drive #(.N(3), .ON_LVL(CE_ON_LVL)) u_ce (.en(ce_en_q), .ce(fl_ce));

  assign rd_ok       = (since_we >= SW'(T_WHGL - 1));
  assign sts_settled = (since_we >= SW'(T_STS));
  assign req_ready   = (st_q == S_IDLE);
  assign accept      = req_ready && req_valid;
  assign we_rise     = (st_q == S_W_PULSE) && (st_d != S_W_PULSE);

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      S_RST_LO: if (tmr_done) begin
        st_d = S_RST_REC; tmr_load = 1'b1; tmr_val = TW'(T_RST_REC - 1);
      end
      S_RST_REC: if (tmr_done) st_d = S_IDLE;
      S_IDLE: if (accept) begin
        if (req_write) begin
          st_d = S_W_LEAD; tmr_load = 1'b1; tmr_val = TW'(T_CE_LEAD - 1);
        end else begin
          st_d = S_R_WAIT;
        end
      end
      S_W_LEAD: if (tmr_done) begin
        st_d = S_W_PULSE; tmr_load = 1'b1; tmr_val = TW'(WE_LOW - 1);
      end
      S_W_PULSE: if (tmr_done) begin
        st_d = S_W_HIGH; tmr_load = 1'b1; tmr_val = TW'(WR_HIGH - 1);
      end
      S_W_HIGH: if (tmr_done) st_d = S_IDLE;
      S_R_WAIT: if (rd_ok) begin
        st_d = S_R_OE; tmr_load = 1'b1; tmr_val = TW'(T_RD_ACC - 1);
      end
      S_R_OE: if (tmr_done) begin
        st_d = S_R_REC; tmr_load = 1'b1; tmr_val = TW'(T_RD_REC - 1);
      end
      S_R_REC: if (tmr_done) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // State and pin registers (pins decoded from next state)
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q      <= S_RST_LO;
      rst_pin_q <= 1'b0;
      ce_en_q   <= 1'b0;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
      rval_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      rst_pin_q <= (st_d != S_RST_LO);
      ce_en_q   <= (st_d == S_W_LEAD) || (st_d == S_W_PULSE) || (st_d == S_R_OE);
      we_n_q    <= (st_d != S_W_PULSE);
      oe_n_q    <= (st_d != S_R_OE);
      dq_oe_q   <= (st_d == S_W_LEAD) || (st_d == S_W_PULSE) || (st_d == S_W_HIGH);
      rval_q    <= (st_q == S_R_OE) && tmr_done;
    end
  end

  // Request capture
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_wdata;
    end
  end

  // Read data capture
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)                           rdat_q <= '0;
    else if ((st_q == S_R_OE) && tmr_done)    rdat_q <= fl_dq_in;
  end

  assign fl_rst_n  = rst_pin_q;
  assign fl_we_n   = we_n_q;
  assign fl_oe_n   = oe_n_q;
  assign fl_addr   = addr_q;
  assign fl_dq_out = data_q;
  assign fl_dq_oe  = dq_oe_q;
  assign rd_data   = rdat_q;
  assign rd_valid  = rval_q;
endmodule

// File: rtl/pfws_chk.sv
module pfws_chk #(
  parameter int         AW        = 23,
  parameter int         DW        = 16,
  parameter logic [2:0] CE_ON_LVL = 3'b010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          sts_settled,
  input logic          fl_rst_n,
  input logic [2:0]    fl_ce,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe
);
  logic ce_on, ce_off;
  assign ce_on  = (fl_ce == CE_ON_LVL);
  assign ce_off = (fl_ce == ~CE_ON_LVL);

  assert_rst_pin_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> (fl_we_n && fl_oe_n && !req_ready));

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (ce_on && fl_dq_oe));

  assert_data_stable_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> ($stable(fl_dq_out) && $stable(fl_addr)));

  assert_ce_release_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> !ce_on);

  assert_read_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_dq_oe && fl_we_n && ce_on));

  assert_rdvalid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_sts_low_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> !sts_settled);

  assert_ce_lines_together_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_on || ce_off);

  assert_busy_ignores_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(fl_addr));
endmodule

bind pflash_wr_seq pfws_chk #(.AW(AW), .DW(DW), .CE_ON_LVL(CE_ON_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .sts_settled(sts_settled), .fl_rst_n(fl_rst_n),
  .fl_ce(fl_ce), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr),
  .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe)
);

// File: tb/sim_pflash_wr_seq.sv
`timescale 1ns/1ps
module sim_pflash_wr_seq;
  localparam int         AW = 23, DW = 16;
  localparam logic [2:0] CE_ON = 3'b010;
  localparam int T_RST_LO = 4, T_RST_REC = 201, T_CE_LEAD = 3, T_WP = 14;
  localparam int T_WP_CREDIT = 2, T_DS = 11, T_DH = 2, T_WPH = 6;
  localparam int T_WHGL = 7, T_STS = 18, T_RD_ACC = 8, T_RD_REC = 6;
  // WE low width per R4: max(14-2, 14-3, 11-3) = 12
  localparam int EXP_WE_LOW = 12;
  localparam int EXP_WR_BUSY = T_CE_LEAD + EXP_WE_LOW + T_WPH + 1;
  localparam logic [DW-1:0] KEY = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid, sts_settled, fl_rst_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [DW-1:0] rd_data, fl_dq_out, fl_dq_in;
  logic [2:0]    fl_ce;
  logic [AW-1:0] fl_addr;

  always #2.5 clk = ~clk;

  assign fl_dq_in = (!fl_oe_n && fl_ce == CE_ON) ? (fl_addr[DW-1:0] ^ KEY) : '0;

  pflash_wr_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .sts_settled(sts_settled),
    .fl_rst_n(fl_rst_n), .fl_ce(fl_ce), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint expv, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Bus monitor: timestamps in cycles, sampled at negedge
  int  cyc = 0, ce_events = 0;
  int  t_rst_rise = -1, t_ce_on = -1, t_we_fall = -1, t_we_rise = -1;
  int  t_first_rise = -1, t_bus = -1, t_oe_fall = -1;
  logic p_rst = 1'b0, p_ce = 1'b0, p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  logic ce_now;

  always @(negedge clk) begin
    cyc++;
    ce_now = (fl_ce == CE_ON);
    if (fl_rst_n && !p_rst) t_rst_rise = cyc;
    if (fl_addr != p_addr || fl_dq_out != p_dq || fl_dq_oe != p_dqoe) begin
      if (t_we_rise >= 0)
        chk(cyc - t_we_rise >= T_DH, "R5", cyc - t_we_rise, T_DH, "bus hold after WE rise");
      t_bus = cyc;
    end
    if (ce_now && !p_ce) begin
      ce_events++;
      t_ce_on = cyc;
      if (t_first_rise >= 0)
        chk(cyc - t_first_rise >= T_WPH, "R6", cyc - t_first_rise, T_WPH, "strobe high gap");
    end
    if ((!ce_now && p_ce) || (fl_we_n && !p_we)) t_first_rise = cyc;
    if (!fl_we_n && p_we) begin
      t_we_fall = cyc;
      chk(cyc - t_rst_rise >= T_RST_REC, "R2", cyc - t_rst_rise, T_RST_REC, "reset to WE fall");
      chk(cyc - t_ce_on == T_CE_LEAD, "R3", cyc - t_ce_on, T_CE_LEAD, "CE lead");
      chk(fl_addr == exp_addr && fl_dq_out == exp_data && fl_dq_oe, "R3",
          fl_dq_out, exp_data, "address/data at WE fall");
    end
    if (fl_we_n && !p_we) begin
      t_we_rise = cyc;
      chk(cyc - t_we_fall == EXP_WE_LOW, "R4", cyc - t_we_fall, EXP_WE_LOW, "WE low width");
      chk(cyc - t_ce_on >= T_WP, "R4", cyc - t_ce_on, T_WP, "effective pulse");
      chk(cyc - t_bus >= T_DS, "R4", cyc - t_bus, T_DS, "data setup");
      chk(!ce_now, "R5", ce_now, 0, "CE released at WE rise");
    end
    if (t_we_rise >= 0 && cyc - t_we_rise == T_STS - 1)
      chk(!sts_settled, "R9", sts_settled, 0, "status window not yet over");
    if (t_we_rise >= 0 && cyc - t_we_rise == T_STS)
      chk(sts_settled, "R9", sts_settled, 1, "status window over");
    if (!fl_oe_n && p_oe) begin
      t_oe_fall = cyc;
      if (t_we_rise >= 0)
        chk(cyc - t_we_rise >= T_WHGL, "R7", cyc - t_we_rise, T_WHGL, "write recovery before OE");
      chk(ce_now && !fl_dq_oe, "R8", fl_dq_oe, 0, "read bus state");
    end
    if (fl_oe_n && !p_oe)
      chk(cyc - t_oe_fall == T_RD_ACC, "R8", cyc - t_oe_fall, T_RD_ACC, "OE low width");
    p_rst = fl_rst_n; p_ce = ce_now; p_we = fl_we_n; p_oe = fl_oe_n;
    p_addr = fl_addr; p_dq = fl_dq_out; p_dqoe = fl_dq_oe;
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) begin exp_addr = a; exp_data = d; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!fl_rst_n && !req_ready && fl_we_n && fl_oe_n, "R1", fl_rst_n, 0, "pins in reset");
    chk(fl_ce == ~CE_ON, "R10", fl_ce, ~CE_ON, "CE idle levels");
    rst_n = 1'b1;
    n = 0;
    while (!fl_rst_n && n < 100) begin @(negedge clk); n++; end
    chk(n == T_RST_LO + 2, "R1", n, T_RST_LO + 2, "reset pin low time");
    n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    chk(n == T_RST_REC, "R2", n, T_RST_REC, "ready after reset pin release");
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    do_req(1'b1, a, d);
    n = 1;
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    chk(n == EXP_WR_BUSY, "R6", n, EXP_WR_BUSY, "ready low during write");
  endtask

  task automatic t_back_to_back();
    t_write(23'h12345, 16'h0F0F);
    t_write(23'h00ABC, 16'hF00D);
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    int n;
    do_req(1'b0, a, '0);
    n = 0;
    while (!rd_valid && n < 200) begin @(negedge clk); n++; end
    chk(rd_valid, "R8", rd_valid, 1, "read completes");
    chk(rd_data == (a[DW-1:0] ^ KEY), "R8", rd_data, a[DW-1:0] ^ KEY, "read data");
    @(negedge clk);
    chk(!rd_valid, "R8", rd_valid, 0, "rd_valid single cycle");
  endtask

  task automatic t_read_after_write();
    t_write(23'h0BEEF, 16'h1357);
    t_read(23'h04321);
  endtask

  task automatic t_ignore_busy();
    int ev;
    do_req(1'b1, 23'h00777, 16'h2468);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 23'h7FFFF; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    ev = ce_events;
    repeat (40) @(negedge clk);
    chk(ce_events == ev, "R11", ce_events, ev, "no cycle from ignored request");
    chk(fl_addr == 23'h00777, "R11", fl_addr, 23'h00777, "address kept");
    chk(sts_settled, "R9", sts_settled, 1, "status settled when idle");
  endtask

  bit finished = 1'b0;
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write(23'h00010, 16'hCAFE);
    t_back_to_back();
    t_read_after_write();
    repeat (30) @(negedge clk);
    t_read(23'h1F00F);
    t_ignore_busy();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule